// File: doc/BRIEF.md
# DRAM Row-Alias Window Remapper

This block reproduces the address wraparound that a DRAM device shows when its controller is programmed with more row address bits than the fitted memory has. Boot firmware sizes memory by setting the widest row geometry, writing a pattern at a row-boundary offset and reading it back. If the same value appears at the start of memory, the firmware knows the real row count. The block makes that probe behave correctly on a model whose real storage is sized by a parameter.

Each strobed write of the controller configuration word updates two things: whether a 4 KiB alias window is live, and where that window sits. The window is placed at a distance from the memory base that follows from the real row count, the programmed bank count and the programmed page size. While the window is live, any request address that falls inside it is folded onto the first 4 KiB at the memory base, and the `remapped` flag is raised. All other addresses pass through unchanged in the same cycle. The block holds no storage for the memory itself.

Top module: `dram_row_alias`

## Requirements
- R1: After a synchronous active-low reset the window is off (`win_en`=0) and its placement `win_base` is MEM_BASE + 1 MiB (0x0010_0000).
- R2: On a strobe the configuration word is decoded as follows. Row bits are bits [7:4] + 1. Bank bits are bit [2] + 2. Page shift is bits [11:8] + 3. When the window is switched on, it is placed at MEM_BASE + 2^(real row bits + bank bits + page shift).
- R3: If the programmed row bits equal the real row bits, a strobe turns the window off and leaves `win_base` unchanged.
- R4: While the window is on, an address A in [win_base, win_base + 4096) gives `out_addr` = MEM_BASE + (A - win_base) and `remapped`=1, combinationally. Every other address gives `out_addr` = A and `remapped`=0.
- R5: The window state changes only at a clock edge where `cfg_wr` is 1. The new state is visible from that edge on and is held until the next strobe.
- R6: A programmed row count below 3 is treated as a mismatch, so the window is switched on.
- R7: The placement is computed modulo 2^ADDR_W. An offset of 2^ADDR_W or more places the window at MEM_BASE, and requests there are then flagged but keep their address.
- R8: MEM_SIZE_MIB must be 256, 512, 1024 or 2048; any other value stops elaboration. The real row bits are log2(MEM_SIZE_MIB) + 3, which is 12 for the default of 512.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr | input | 1 | Strobe: decode `cfg_data` this cycle |
| cfg_data | input | 32 | Controller configuration word |
| req_addr | input | ADDR_W | Incoming memory request address |
| out_addr | output | ADDR_W | Translated request address |
| remapped | output | 1 | Request fell inside the live window |
| win_en | output | 1 | Alias window is live |
| win_base | output | ADDR_W | Current window placement |

## Verification
A wrong window enable or placement shows up on `win_en` and `win_base` in the cycle after the strobe edge. It then shows on every later probe address near the window, because those addresses are either folded to the base or wrongly passed through. Boundary probes at the window's first and last byte, one byte on each side of it, and probes after a strobe that disables the window expose off-by-one and stale-state faults at once. Because translation is combinational, a fault in the range compare or in the offset arithmetic is visible in the same cycle the address is applied.

// File: rtl/dram_row_alias_pkg.sv
// Package: shared geometry type for the row-alias remapper.
// Assumes configuration fields are at most 4 bits wide before biasing.
package dram_row_alias_pkg;

    // Decoded geometry of one configuration word.
    typedef struct packed {
        logic [4:0] row_bits;     // programmed row address bits (1..16)
        logic [1:0] bank_bits;    // programmed bank address bits (2..3)
        logic [4:0] page_shift;   // log2 of page size in bytes (3..18)
        logic       geom_match;   // programmed rows equal fitted rows
        logic [5:0] alias_shift;  // log2 of window offset from base
    } geom_t;

    // Real row bits from the fitted size in MiB; 0 means unsupported.
    function automatic int real_row_bits(input int size_mib);
        int rb;
        rb = 0;
        for (int i = 8; i <= 11; i++) begin
            if ((1 << i) == size_mib) rb = i + 3;
        end
        return rb;
    endfunction

endpackage

// File: rtl/dram_row_alias_decode.sv
// Module: dram_row_alias_decode
// Splits a configuration word into row, bank and page fields. It then
// decides whether the programmed row count matches the fitted memory and
// derives the shift that places the alias window.
// Assumes REAL_RB is a valid row count (11..14). Purely combinational.
module dram_row_alias_decode
    import dram_row_alias_pkg::*;
#(
    parameter int REAL_RB = 12
) (
    input  logic [11:0] cfg_field,
    output geom_t       geom
);

    localparam logic [4:0] REAL_RB_W = 5'(REAL_RB);
    localparam logic [4:0] MIN_RB    = 5'd3;

    logic [4:0] rb;
    logic [1:0] bb;
    logic [4:0] ps;
    logic       rb_ok;

    // Field extraction with the fixed biases of each field.
    always_comb begin
        rb = {1'b0, cfg_field[7:4]} + 5'd1;
        bb = {1'b0, cfg_field[2]} + 2'd2;
        ps = {1'b0, cfg_field[11:8]} + 5'd3;
    end

    // A row count below 3 cannot be compared by shifting; call it a mismatch.
    always_comb begin
        rb_ok = (rb >= MIN_RB);
    end

    // Assemble the geometry record and the window offset shift.
    always_comb begin
        geom.row_bits    = rb;
        geom.bank_bits   = bb;
        geom.page_shift  = ps;
        geom.geom_match  = rb_ok && (rb == REAL_RB_W);
        geom.alias_shift = 6'(REAL_RB_W) + 6'(bb) + 6'(ps);
    end

endmodule

// File: rtl/dram_row_alias_window.sv
// Module: dram_row_alias_window
// Holds the alias window state (enable and placement). It loads a new
// state only on the configuration strobe.
// Assumes synchronous active-low reset; placement wraps at ADDR_W bits.
module dram_row_alias_window
    import dram_row_alias_pkg::*;
#(
    parameter int              ADDR_W   = 32,
    parameter logic [ADDR_W-1:0] MEM_BASE = '0,
    parameter int              RST_OFS  = 32'h0010_0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  geom_t             geom,
    output logic              en,
    output logic [ADDR_W-1:0] base
);

    localparam logic [ADDR_W-1:0] RST_BASE = MEM_BASE + ADDR_W'(RST_OFS);

    logic [ADDR_W-1:0] offset;
    logic [ADDR_W-1:0] next_base;

    // One-hot offset; a shift at or past the width leaves zero (wrap).
    always_comb begin
        if (int'(geom.alias_shift) < ADDR_W) begin
            offset = ADDR_W'(1) << geom.alias_shift;
        end else begin
            offset = '0;
        end
        next_base = MEM_BASE + offset;
    end

    // State register: reset default, else load on strobe only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en   <= 1'b0;
            base <= RST_BASE;
        end else if (load) begin
            if (geom.geom_match) begin
                en <= 1'b0;
            end else begin
                en   <= 1'b1;
                base <= next_base;
            end
        end
    end

endmodule

// File: rtl/dram_row_alias_xlate.sv
// Module: dram_row_alias_xlate
// Folds request addresses that land in the live window onto the first
// WIN_BYTES at the memory base. Other addresses pass unchanged.
// Assumes WIN_BYTES is a power of two. Purely combinational.
module dram_row_alias_xlate #(
    parameter int                ADDR_W    = 32,
    parameter logic [ADDR_W-1:0] MEM_BASE  = '0,
    parameter int                WIN_BYTES = 4096
) (
    input  logic              en,
    input  logic [ADDR_W-1:0] base,
    input  logic [ADDR_W-1:0] addr_in,
    output logic [ADDR_W-1:0] addr_out,
    output logic              hit
);

    localparam logic [ADDR_W-1:0] WIN_LIM = ADDR_W'(WIN_BYTES);

    logic [ADDR_W-1:0] delta;

    // Distance from the window start, modulo the address width.
    always_comb begin
        delta = addr_in - base;
    end

    // Range test and selection of the translated address.
    always_comb begin
        hit      = en && (delta < WIN_LIM);
        addr_out = hit ? (MEM_BASE + delta) : addr_in;
    end

endmodule

// File: rtl/dram_row_alias.sv
// Module: dram_row_alias (top)
// Models DRAM row wraparound for memory-sizing probes. A strobed
// configuration word sets a 4 KiB alias window, and requests inside that
// window are folded onto the start of memory.
// Assumes MEM_SIZE_MIB is one of 256/512/1024/2048. Any other value
// stops elaboration.
module dram_row_alias
    import dram_row_alias_pkg::*;
#(
    parameter int                ADDR_W       = 32,
    parameter logic [ADDR_W-1:0] MEM_BASE     = 32'h4000_0000,
    parameter int                MEM_SIZE_MIB = 512,
    parameter int                WIN_BYTES    = 4096
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic [31:0]       cfg_data,
    input  logic [ADDR_W-1:0] req_addr,
    output logic [ADDR_W-1:0] out_addr,
    output logic              remapped,
    output logic              win_en,
    output logic [ADDR_W-1:0] win_base
);

    localparam int REAL_RB = real_row_bits(MEM_SIZE_MIB);
    localparam int RST_OFS = 1 << 20;

    // Reject unsupported fitted sizes at elaboration.
    generate
        if (REAL_RB == 0) begin : g_bad_size
            $error("dram_row_alias: MEM_SIZE_MIB must be 256, 512, 1024 or 2048");
        end
    endgenerate

    geom_t geom;
    logic  unused_cfg;

    // Configuration bits without a function in this block.
    assign unused_cfg = ^{cfg_data[31:12], cfg_data[3], cfg_data[1:0]};

    dram_row_alias_decode #(
        .REAL_RB (REAL_RB)
    ) u_decode (
        .cfg_field (cfg_data[11:0]),
        .geom      (geom)
    );

    dram_row_alias_window #(
        .ADDR_W   (ADDR_W),
        .MEM_BASE (MEM_BASE),
        .RST_OFS  (RST_OFS)
    ) u_window (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (cfg_wr),
        .geom  (geom),
        .en    (win_en),
        .base  (win_base)
    );

    dram_row_alias_xlate #(
        .ADDR_W    (ADDR_W),
        .MEM_BASE  (MEM_BASE),
        .WIN_BYTES (WIN_BYTES)
    ) u_xlate (
        .en       (win_en),
        .base     (win_base),
        .addr_in  (req_addr),
        .addr_out (out_addr),
        .hit      (remapped)
    );

endmodule

// File: rtl/dram_row_alias_chk.sv
// Module: dram_row_alias_chk
// Property checker bound to dram_row_alias. It relates the strobe, the
// window state and the translation at the ports.
module dram_row_alias_chk #(
    parameter int                ADDR_W       = 32,
    parameter logic [ADDR_W-1:0] MEM_BASE     = 32'h4000_0000,
    parameter int                MEM_SIZE_MIB = 512,
    parameter int                WIN_BYTES    = 4096
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_wr,
    input logic [31:0]       cfg_data,
    input logic [ADDR_W-1:0] req_addr,
    input logic [ADDR_W-1:0] out_addr,
    input logic              remapped,
    input logic              win_en,
    input logic [ADDR_W-1:0] win_base
);

    localparam int         REAL_RB  = $clog2(MEM_SIZE_MIB) + 3;
    localparam logic [3:0] MATCH_RF = 4'(REAL_RB - 1);
    localparam logic [ADDR_W-1:0] WIN_LIM = ADDR_W'(WIN_BYTES);

    logic unused_chk;
    assign unused_chk = ^{cfg_data[31:8], cfg_data[3:0]};

    AST_HOLD_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_wr |=> ($stable(win_en) && $stable(win_base))); // R5

    AST_MATCH_DISABLES: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && cfg_data[7:4] == MATCH_RF) |=> (!win_en && $stable(win_base))); // R3

    AST_OFF_NO_FOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !win_en |-> !remapped); // R4

    AST_PASS_UNCHANGED: assert property (@(posedge clk) disable iff (!rst_n)
        !remapped |-> (out_addr == req_addr)); // R4

    AST_FOLD_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        remapped |-> ((out_addr - MEM_BASE) < WIN_LIM)); // R4

    AST_FOLD_KEEPS_OFS: assert property (@(posedge clk) disable iff (!rst_n)
        remapped |-> ((req_addr - win_base) == (out_addr - MEM_BASE))); // R4

    AST_LOW_ROWS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && cfg_data[7:4] < 4'd2) |=> win_en); // R6

endmodule

bind dram_row_alias dram_row_alias_chk #(
    .ADDR_W       (ADDR_W),
    .MEM_BASE     (MEM_BASE),
    .MEM_SIZE_MIB (MEM_SIZE_MIB),
    .WIN_BYTES    (WIN_BYTES)
) u_chk (.*);

// File: tb/dram_row_alias_test.sv
// Scoreboard bench: the driver pushes expected translations, and the
// monitor pops each one and compares it against the ports.
module dram_row_alias_test;

    localparam int          AW    = 32;
    localparam logic [31:0] BASE  = 32'h4000_0000;
    localparam int          SIZE  = 512;
    localparam int          WIN   = 4096;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_wr = 1'b0;
    logic [31:0]   cfg_data = '0;
    logic [AW-1:0] req_addr = '0;
    logic [AW-1:0] out_addr;
    logic          remapped;
    logic          win_en;
    logic [AW-1:0] win_base;

    int tests = 0;
    int fails = 0;
    bit done  = 0;

    // Bench-side model of the window state.
    bit          m_en;
    logic [31:0] m_base;

    typedef struct {
        logic [31:0] addr;
        logic [31:0] exp_out;
        bit          exp_rem;
        string       tag;
    } item_t;

    item_t sb[$];
    event  mon_ev;

    dram_row_alias #(
        .ADDR_W(AW), .MEM_BASE(BASE), .MEM_SIZE_MIB(SIZE), .WIN_BYTES(WIN)
    ) uut (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_data(cfg_data),
        .req_addr(req_addr), .out_addr(out_addr), .remapped(remapped),
        .win_en(win_en), .win_base(win_base)
    );

    always #5 clk = ~clk;

    // Monitor: pop and compare each expected item.
    initial begin
        forever begin
            @(mon_ev);
            if (sb.size() != 0) begin
                item_t it;
                it = sb.pop_front();
                tests++;
                if (out_addr !== it.exp_out || remapped !== it.exp_rem) begin
                    fails++;
                    $display("FAIL %s addr=%h out=%h rem=%0b expected out=%h rem=%0b",
                             it.tag, it.addr, out_addr, remapped, it.exp_out, it.exp_rem);
                end
            end
        end
    end

    // Model of the window update from a configuration word.
    task automatic model_cfg(input logic [31:0] w);
        int          rows = int'(w[7:4]) + 1;
        longint      pg = 1;
        longint      span = 1;
        bit          same;
        same = (rows >= 3) && (SIZE == (1 << (rows - 3)));
        if (same) begin
            m_en = 0;
        end else begin
            repeat (int'(w[11:8]) + 3) pg = pg * 2;
            repeat (12 + int'(w[2]) + 2) span = span * 2;
            m_en   = 1;
            m_base = 32'(longint'(BASE) + span * pg);
        end
    endtask

    // Driver: strobe a configuration word (called just after a negedge).
    task automatic write_cfg(input logic [31:0] w);
        cfg_data = w;
        cfg_wr   = 1'b1;
        @(negedge clk);
        cfg_wr   = 1'b0;
        model_cfg(w);
    endtask

    // Driver: present an address and push its expected translation.
    task automatic probe(input logic [31:0] a, input string tag);
        item_t it;
        longint d;
        req_addr = a;
        d = longint'(a) - longint'(m_base);
        it.addr = a;
        it.tag  = tag;
        if (m_en && d >= 0 && d < WIN) begin
            it.exp_out = 32'(longint'(BASE) + d);
            it.exp_rem = 1;
        end else begin
            it.exp_out = a;
            it.exp_rem = 0;
        end
        sb.push_back(it);
        #1 -> mon_ev;
        #1;
    endtask

    // Direct check of the window state outputs.
    task automatic check_win(input string tag);
        tests++;
        if (win_en !== m_en || (m_en && win_base !== m_base)) begin
            fails++;
            $display("FAIL %s win_en=%0b base=%h expected en=%0b base=%h",
                     tag, win_en, win_base, m_en, m_base);
        end
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    // Stimulus.
    initial begin
        m_en = 0;
        m_base = BASE + 32'h0010_0000;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state, placement held at base + 1 MiB.
        tests++;
        if (win_en !== 1'b0 || win_base !== BASE + 32'h0010_0000) begin
            fails++;
            $display("FAIL R1 en=%0b base=%h expected en=0 base=%h",
                     win_en, win_base, BASE + 32'h0010_0000);
        end
        probe(BASE + 32'h0010_0008, "R1 disabled window passes");

        // R2/R8: rows 16, bank 3, page shift 6 -> offset 2^(12+3+6)=2 MiB.
        write_cfg(32'h0000_03F4);
        check_win("R2 placement");
        probe(BASE + 32'h0020_0010, "R2 inside window");
        probe(BASE + 32'h0020_0000, "R4 first byte");
        probe(BASE + 32'h0020_0FFF, "R4 last byte");
        probe(BASE + 32'h0020_1000, "R4 one past end");
        probe(BASE + 32'h001F_FFFF, "R4 one before start");

        // R2: bank bit clear moves the window to 2^(12+2+6)=1 MiB.
        write_cfg(32'h0000_03F0);
        check_win("R2 bank bit");
        probe(BASE + 32'h0010_0040, "R2 bank 2 window");
        probe(BASE + 32'h0020_0040, "R2 old window gone");

        // R5: new word without strobe leaves the window untouched.
        cfg_data = 32'h0000_0FB4;
        repeat (3) @(negedge clk);
        check_win("R5 hold without strobe");
        probe(BASE + 32'h0010_0004, "R5 still folds");

        // R3/R8: rows 12 equals real rows -> disabled, placement kept.
        write_cfg(32'h0000_00B0);
        check_win("R3 match disables");
        tests++;
        if (win_base !== BASE + 32'h0010_0000) begin
            fails++;
            $display("FAIL R3 base moved to %h expected %h", win_base, BASE + 32'h0010_0000);
        end
        probe(BASE + 32'h0010_0004, "R3 disabled passes");

        // R6: row field 0 -> rows 1 is a mismatch; page shift 3 -> 2^17.
        write_cfg(32'h0000_0000);
        check_win("R6 low rows enable");
        probe(BASE + 32'h0002_0100, "R6 folds");

        // R7: page shift 18 -> 2^(12+2+18)=2^32 wraps to base.
        write_cfg(32'h0000_0F70);
        check_win("R7 wrap to base");
        probe(BASE + 32'h0000_0020, "R7 base window keeps addr");
        probe(BASE + 32'h0000_1000, "R7 beyond window");

        // R8: rows 11 is a mismatch against 12 real rows; page shift 4.
        write_cfg(32'h0000_01A0);
        check_win("R8 real rows 12");
        probe(BASE + 32'h0004_0FF0, "R8 folds at 2^18");

        @(negedge clk);
        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule